// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator

This block drives two or three pulse-width-modulated phase outputs from one shared period counter. Each phase is ended, not started, by a staggered termination event. After that event the phase is held low for a forced off interval of one third of the period. After the interval it rises as soon as its own sawtooth count reaches the duty command minus a per-phase correction term. It then stays high until its next termination event. The sawtooth of each phase restarts at that phase's termination, so all phases share one ramp shape that is shifted in time.

A mode input selects three-phase or two-phase interleaving. In two-phase mode the third output is parked low. Next to each output the block gives a one-cycle termination strobe. Control logic can use this strobe to time sampling of the phase current during the forced off interval. The period is a programmable count of clock cycles. It should be a multiple of 6 (and at least 6) so that every offset and interval is exact.

Top module: `mphase_pwm`

## Requirements
- R1: While `rst_n` is low, all `pwm_o` and `term_stb_o` bits are 0. The first clock edge after release is a phase-1 termination, so `term_stb_o[0]` is high in the first cycle after release.
- R2: `term_stb_o[0]` (phase 1) pulses for one cycle every `period_i` cycles. This interval defines the switching cycle.
- R3: With `two_phase_i` = 0, `term_stb_o[1]` pulses `period_i`/3 cycles after `term_stb_o[0]`, and `term_stb_o[2]` pulses `period_i`/3 cycles after `term_stb_o[1]`.
- R4: With `two_phase_i` = 1, `term_stb_o[1]` pulses `period_i`/2 cycles after `term_stb_o[0]`. Bit 2 of both `pwm_o` and `term_stb_o` stays 0.
- R5: In the cycle in which a phase's strobe is high, that phase's `pwm_o` bit is 0.
- R6: A phase's output stays 0 for the cycle of its strobe and the following `period_i`/3 - 1 cycles. This forced off interval spans `period_i`/3 cycles.
- R7: Let r be the number of cycles since the phase's strobe cycle, and let cmp = `duty_i` - `corr_i[k]`, clamped to 0 when the correction exceeds the duty. The output is first high at r = max(`period_i`/3, cmp).
- R8: Once high, a phase stays high through the remaining cycles of its period. It goes low only at its next termination strobe.
- R9: If cmp ≥ `period_i`, the phase stays low for the whole period and makes no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Switching period in clock cycles (multiple of 6) |
| duty_i | input | CNT_W | Shared duty command, in ramp counts |
| corr_i | input | 3 x CNT_W | Per-phase correction subtracted from the duty command, index k for phase k+1 |
| two_phase_i | input | 1 | 1 selects two-phase interleave, 0 selects three-phase |
| pwm_o | output | 3 | PWM outputs, bit k is phase k+1 |
| term_stb_o | output | 3 | One-cycle termination strobe per phase, coincident with the forced low |

## Verification
The outputs are registered. The value seen in a cycle is the decision taken at the preceding edge from the counter position held there. The scoreboard driver therefore computes the expected item for counter position c at each rising edge. It derives the item from closed-form formulas: ramp r = (c - offset) mod period, high when r ≥ max(period/3, cmp), strobe when r = 0. The monitor compares at the next falling edge, so each result is due exactly one edge after the counter position it belongs to. Inputs change only while reset is held, and the queue is drained before the next setting is applied, so no expected item spans two settings.

// File: rtl/mpwm_pkg.sv
`timescale 1ns/1ps
package mpwm_pkg;

  // Interleave mode selected by the mode pin.
  typedef enum logic {
    MODE_TRI  = 1'b0,
    MODE_DUAL = 1'b1
  } mode_e;

  // Registered result of one phase slice.
  typedef struct packed {
    logic pwm;
    logic stb;
  } ph_out_t;

  localparam int unsigned NUM_PH = 3;

endpackage

// File: rtl/mpwm_timebase.sv
`timescale 1ns/1ps
module mpwm_timebase #(
  parameter int unsigned CW  = 12,
  parameter int unsigned NPH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CW-1:0]           period_i,
  input  mpwm_pkg::mode_e         mode_i,
  output logic [NPH-1:0]          term_o,
  output logic [NPH-1:0][CW-1:0]  ramp_o,
  output logic [CW-1:0]           third_o
);

  logic [CW-1:0]          cnt_q;
  logic [CW-1:0]          cnt_d;
  logic                   wrap;
  logic [CW-1:0]          third;
  logic [CW-1:0]          half;
  logic [NPH-1:0][CW-1:0] off;

  assign third = period_i / CW'(3);
  assign half  = period_i >> 1;

  // Wrap at the end of the period; cnt = 0 is the phase-1 termination point.
  assign wrap = (period_i <= CW'(1)) || (cnt_q >= period_i - CW'(1));

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  genvar k;
  generate
    for (k = 0; k < NPH; k++) begin : g_off
      // Termination offset of phase k within the period.
      assign off[k] = (mode_i == mpwm_pkg::MODE_DUAL) ? (CW'(k) * half)
                                                      : (CW'(k) * third);
      assign term_o[k] = (cnt_q == off[k]);
      // Ramp is the distance since this phase's own termination, modulo period.
      assign ramp_o[k] = (cnt_q >= off[k]) ? (cnt_q - off[k])
                                           : (cnt_q + period_i - off[k]);
    end
  endgenerate

  assign third_o = third;

  // The counter only ever steps by one or returns to zero.
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1));

  // Phase-1 termination is followed by position 1 for any usable period.
  assert_period_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (term_o[0] && period_i >= CW'(6) && $stable(period_i)) |=> (cnt_q == CW'(1)));

endmodule

// File: rtl/mpwm_phase.sv
`timescale 1ns/1ps
module mpwm_phase #(
  parameter int unsigned CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              term_i,
  input  logic [CW-1:0]     ramp_i,
  input  logic [CW-1:0]     third_i,
  input  logic [CW-1:0]     duty_i,
  input  logic [CW-1:0]     corr_i,
  output mpwm_pkg::ph_out_t out_o
);

  logic [CW-1:0] cmp;
  logic          set_ok;
  logic          pwm_q, pwm_d;
  logic          stb_q, stb_d;

  // Compare level, clamped at zero when the correction exceeds the command.
  assign cmp = (corr_i > duty_i) ? '0 : (duty_i - corr_i);

  // Rise allowed only once the forced off interval is over and the ramp crossed.
  assign set_ok = (ramp_i >= third_i) && (ramp_i >= cmp);

  always_comb begin
    pwm_d = pwm_q;
    stb_d = 1'b0;
    if (!en_i) begin
      pwm_d = 1'b0;
    end else if (term_i) begin
      pwm_d = 1'b0;
      stb_d = 1'b1;
    end else if (set_ok) begin
      pwm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
      stb_q <= stb_d;
    end
  end

  assign out_o.pwm = pwm_q;
  assign out_o.stb = stb_q;

  // Checker state: cycles since the last termination strobe, saturating.
  logic [CW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     since_q <= '1;
    else if (stb_d) since_q <= '0;
    else if (since_q != '1) since_q <= since_q + 1'b1;
  end

  assert_term_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> !pwm_q);

  assert_off_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(third_i) && since_q < third_i) |-> !pwm_q);

  assert_fall_only_at_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_q) && $past(en_i)) |-> stb_q);

endmodule

// File: rtl/mphase_pwm.sv
`timescale 1ns/1ps
module mphase_pwm #(
  parameter int unsigned CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      period_i,
  input  logic [CNT_W-1:0]      duty_i,
  input  logic [2:0][CNT_W-1:0] corr_i,
  input  logic                  two_phase_i,
  output logic [2:0]            pwm_o,
  output logic [2:0]            term_stb_o
);

  localparam int unsigned NPH = mpwm_pkg::NUM_PH;

  mpwm_pkg::mode_e                mode;
  logic [NPH-1:0]                 term;
  logic [NPH-1:0][CNT_W-1:0]      ramp;
  logic [CNT_W-1:0]               third;
  mpwm_pkg::ph_out_t [NPH-1:0]    ph_out;

  assign mode = mpwm_pkg::mode_e'(two_phase_i);

  mpwm_timebase #(.CW(CNT_W), .NPH(NPH)) i_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .mode_i   (mode),
    .term_o   (term),
    .ramp_o   (ramp),
    .third_o  (third)
  );

  genvar k;
  generate
    for (k = 0; k < NPH; k++) begin : g_ph
      logic en;
      if (k < 2) begin : g_always_on
        assign en = 1'b1;
      end else begin : g_tri_only
        assign en = (mode == mpwm_pkg::MODE_TRI);
      end

      mpwm_phase #(.CW(CNT_W)) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .term_i  (term[k]),
        .ramp_i  (ramp[k]),
        .third_i (third),
        .duty_i  (duty_i),
        .corr_i  (corr_i[k]),
        .out_o   (ph_out[k])
      );

      assign pwm_o[k]      = ph_out[k].pwm;
      assign term_stb_o[k] = ph_out[k].stb;
    end
  endgenerate

  assert_dual_parks_ph3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    two_phase_i |=> (!pwm_o[2] && !term_stb_o[2]));

  assert_stb_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i >= CNT_W'(6)) |-> $onehot0(term_stb_o));

endmodule

// File: tb/test_mphase_pwm.sv
`timescale 1ns/1ps
module test_mphase_pwm;

  localparam int CW = 12;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [CW-1:0]       period;
  logic [CW-1:0]       duty;
  logic [2:0][CW-1:0]  corr;
  logic                two_phase;
  logic [2:0]          pwm;
  logic [2:0]          stb;

  typedef struct packed {
    logic [2:0]       pwm;
    logic [2:0]       stb;
    logic [2:0][15:0] r;
    logic [2:0][15:0] thr;
    logic             first;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cur_p;
  bit   cur_tp;

  always #5 clk = ~clk;

  mphase_pwm #(.CNT_W(CW)) i_mphase_pwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_i    (period),
    .duty_i      (duty),
    .corr_i      (corr),
    .two_phase_i (two_phase),
    .pwm_o       (pwm),
    .term_stb_o  (stb)
  );

  function automatic string tag_of(bit is_stb, int k, exp_t e);
    int third;
    third = cur_p / 3;
    if (is_stb && k == 0 && e.first) return "R1";
    if (cur_tp && k == 2)            return "R4";
    if (is_stb) return (k == 0) ? "R2" : (cur_tp ? "R4" : "R3");
    if (e.r[k] == 0)                 return "R5";
    if (int'(e.r[k]) < third)        return "R6";
    if (e.pwm[k]) return (e.r[k] == e.thr[k]) ? "R7" : "R8";
    return (int'(e.thr[k]) >= cur_p) ? "R9" : "R7";
  endfunction

  // Monitor: pops one expected item per cycle, away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      for (int k = 0; k < 3; k++) begin
        n_chk++;
        if (stb[k] !== e.stb[k]) begin
          n_bad++;
          $display("FAIL %s phase %0d strobe: actual %0b expected %0b",
                   tag_of(1'b1, k, e), k + 1, stb[k], e.stb[k]);
        end
        n_chk++;
        if (pwm[k] !== e.pwm[k]) begin
          n_bad++;
          $display("FAIL %s phase %0d pwm at r=%0d: actual %0b expected %0b",
                   tag_of(1'b0, k, e), k + 1, e.r[k], pwm[k], e.pwm[k]);
        end
      end
    end
  end

  // Driver: applies a setting under reset, then pushes expectations per edge.
  task automatic run_cfg(input int p, input int d, input int c0, input int c1,
                         input int c2, input bit tp, input int ncyc);
    int third;
    int off [3];
    int cmp;
    exp_t e;
    @(negedge clk);
    period    = CW'(p);
    duty      = CW'(d);
    corr[0]   = CW'(c0);
    corr[1]   = CW'(c1);
    corr[2]   = CW'(c2);
    two_phase = tp;
    cur_p     = p;
    cur_tp    = tp;
    rst_n     = 1'b0;
    #1;
    n_chk++;
    if (pwm !== 3'b000 || stb !== 3'b000) begin
      n_bad++;
      $display("FAIL R1 reset outputs: actual pwm=%b stb=%b expected 000/000", pwm, stb);
    end
    @(negedge clk);
    @(negedge clk);
    n_chk++;
    if (pwm !== 3'b000 || stb !== 3'b000) begin
      n_bad++;
      $display("FAIL R1 held reset: actual pwm=%b stb=%b expected 000/000", pwm, stb);
    end
    third  = p / 3;
    off[0] = 0;
    off[1] = tp ? p / 2 : third;
    off[2] = 2 * third;
    rst_n  = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk);
      e = '0;
      e.first = (i == 0);
      for (int k = 0; k < 3; k++) begin
        int r;
        int cv;
        cv  = (k == 0) ? c0 : ((k == 1) ? c1 : c2);
        cmp = (cv > d) ? 0 : d - cv;
        r   = ((i % p) - off[k] + p) % p;
        e.r[k]   = 16'(r);
        e.thr[k] = 16'((cmp > third) ? cmp : third);
        if (tp && k == 2) begin
          e.pwm[k] = 1'b0;
          e.stb[k] = 1'b0;
        end else begin
          e.pwm[k] = (r >= int'(e.thr[k]));
          e.stb[k] = (r == 0);
        end
      end
      sb_q.push_back(e);
    end
    wait (sb_q.size() == 0);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    period    = '0;
    duty      = '0;
    corr      = '0;
    two_phase = 1'b0;
    // R1 R2 R3 R5 R8: plain three-phase, compare beyond the off interval
    run_cfg(12, 6, 0, 0, 0, 1'b0, 40);
    // R6: small command, forced off interval dominates
    run_cfg(12, 2, 0, 0, 0, 1'b0, 36);
    // R7: distinct per-phase corrections give distinct rise points
    run_cfg(24, 14, 0, 3, 10, 1'b0, 60);
    // R7: correction above the command clamps the compare level to zero
    run_cfg(18, 3, 5, 0, 9, 1'b0, 54);
    // R9: compare at or past the period never crosses; R7 rise on last count
    run_cfg(12, 20, 8, 0, 9, 1'b0, 40);
    // R4: two-phase interleave, third phase parked
    run_cfg(18, 10, 0, 1, 0, 1'b1, 54);
    run_cfg(30, 0, 0, 0, 0, 1'b1, 70);
    // R3: longer period in three-phase mode
    run_cfg(36, 20, 2, 0, 4, 1'b0, 80);
    summary();
    $finish;
  end

endmodule